// File: doc/BRIEF.md
# Unaligned Access Bus Sequencer

This block connects a processor load/store port to a 16-bit external data bus. A request names a byte address, an access size (one, two or four bytes) and a direction. The sequencer splits the request into as many bus beats as the address alignment requires. For writes it places each byte on the proper half of the bus. For reads it collects the returned bytes into a right-justified result. Values are held least significant byte first: the byte at the request address is bits 7:0 of the value, and each following address holds the next more significant byte.

On the bus, every beat presents an even (halfword) address. The byte at that even address travels on bits 15:8 and the byte at the following odd address on bits 7:0. Each half has its own enable. A request at an odd address costs more beats than an even one of the same size. The sequencer waits on a ready handshake for each beat. It then reports completion with a single-cycle done pulse, and read data is valid in that same cycle.

Top module: `unal_bus_seq`

## Requirements
- R1: Size code 0 is one byte, 1 is two bytes, 2 is four bytes. A one-byte access at an even address is a single beat with only the high lane (bits 15:8) enabled. Read results are zero-extended above the bytes read.
- R2: A one-byte access at an odd address is a single beat with only the low lane (bits 7:0) enabled, addressed at the request address minus one.
- R3: A two-byte access at an even address n is one beat at n with both lanes enabled. The read result is bus bits 15:8 as result bits 7:0 and bus bits 7:0 as result bits 15:8.
- R4: A four-byte access at an even address n is two beats, first at n and then at n+2, both with both lanes enabled.
- R5: A two-byte access at an odd address n is two beats. The first is at n-1 with only the low lane enabled. The second is at n+1 with only the high lane enabled.
- R6: A four-byte access at an odd address n is three beats: n-1 with the low lane only, n+1 with both lanes, and n+3 with the high lane only.
- R7: Every beat address has bit 0 cleared. Addresses wrap modulo 2^32.
- R8: On writes, an enabled lane carries the value byte belonging to that lane's byte address, and a disabled lane is driven to zero.
- R9: While a beat is requested and ready is low, the beat address, lane enables and write data hold steady, and the sequencer does not advance.
- R10: done is high for exactly one cycle, the cycle after the final beat is accepted with ready, and rd_data holds the read result in that cycle. After reset, done and bus_req are low.
- R11: A start pulse while an access is in progress or completing is ignored. It produces no beats and no done.
- R12: Read data on a disabled lane never reaches the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| addr | input | 32 | Byte address of the request |
| size | input | 2 | 0 byte, 1 two bytes, 2 four bytes |
| we | input | 1 | 1 write, 0 read |
| wdata | input | 32 | Right-justified write value |
| rd_data | output | 32 | Right-justified read result |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Beat requested |
| bus_addr | output | 32 | Beat address, bit 0 zero |
| bus_we | output | 1 | Beat direction |
| bus_lane_hi | output | 1 | Enable for bits 15:8 (even byte) |
| bus_lane_lo | output | 1 | Enable for bits 7:0 (odd byte) |
| bus_wdata | output | 16 | Write data for the beat |
| bus_rdata | input | 16 | Read data for the beat |
| bus_ready | input | 1 | Beat accepted at this clock edge |

## Verification
The assertions assume the bus side only completes a beat by raising bus_ready while bus_req is high, and that ready may stay low for any number of cycles. The bench responder meets this by deciding ready half a clock before each edge, and alternates between always-ready and a periodic stall pattern. The assertions also assume the requester waits for done before issuing its next real request. The driver does this, and sends extra start pulses only during a busy phase to probe that they are ignored. Size code 3 is never applied.

// File: rtl/unal_seq_pkg.sv
package unal_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } seq_st_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Byte count for a size code; code 3 is treated as four bytes.
    function automatic int unsigned size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/unal_beat_plan.sv
// Works out one bus beat from the item base address and the byte pointer.
module unal_beat_plan #(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  nbytes,
    output logic [ADDR_W-1:0] word_addr,
    output logic              lane_hi,
    output logic              lane_lo,
    output logic [PTR_W-1:0]  step,
    output logic              last
);
    logic [ADDR_W-1:0] cur_addr;
    logic [PTR_W-1:0]  remain;

    always_comb begin
        cur_addr  = base + ADDR_W'(ptr);
        remain    = nbytes - ptr;
        // Even byte rides the high lane, odd byte the low lane.
        lane_hi   = ~cur_addr[0];
        lane_lo   = cur_addr[0] | (remain >= PTR_W'(2));
        step      = (lane_hi & lane_lo) ? PTR_W'(2) : PTR_W'(1);
        last      = (ptr + step) == nbytes;
        word_addr = {cur_addr[ADDR_W-1:1], 1'b0};
    end
endmodule

// File: rtl/unal_wr_steer.sv
// Places value bytes on the bus lanes for one write beat.
module unal_wr_steer #(
    parameter int REG_BYTES = 4,
    parameter int PTR_W     = 3
) (
    input  logic [REG_BYTES*8-1:0] value,
    input  logic [PTR_W-1:0]       ptr,
    input  logic                   lane_hi,
    input  logic                   lane_lo,
    output logic [15:0]            bus_wdata
);
    logic [PTR_W-1:0] lo_idx;
    logic [7:0]       hi_byte;
    logic [7:0]       lo_byte;

    always_comb begin
        lo_idx  = lane_hi ? ptr + PTR_W'(1) : ptr;
        hi_byte = '0;
        lo_byte = '0;
        for (int i = 0; i < REG_BYTES; i++) begin
            if (lane_hi && PTR_W'(i) == ptr)    hi_byte = value[i*8 +: 8];
            if (lane_lo && PTR_W'(i) == lo_idx) lo_byte = value[i*8 +: 8];
        end
        bus_wdata = {hi_byte, lo_byte};
    end
endmodule

// File: rtl/unal_rd_gather.sv
// Merges the enabled lanes of one read beat into the result accumulator.
module unal_rd_gather #(
    parameter int REG_BYTES = 4,
    parameter int PTR_W     = 3
) (
    input  logic [REG_BYTES*8-1:0] acc_in,
    input  logic [15:0]            bus_rdata,
    input  logic [PTR_W-1:0]       ptr,
    input  logic                   lane_hi,
    input  logic                   lane_lo,
    output logic [REG_BYTES*8-1:0] acc_out
);
    logic [PTR_W-1:0] lo_idx;

    always_comb begin
        lo_idx  = lane_hi ? ptr + PTR_W'(1) : ptr;
        acc_out = acc_in;
        for (int i = 0; i < REG_BYTES; i++) begin
            if (lane_hi && PTR_W'(i) == ptr)    acc_out[i*8 +: 8] = bus_rdata[15:8];
            if (lane_lo && PTR_W'(i) == lo_idx) acc_out[i*8 +: 8] = bus_rdata[7:0];
        end
    end
endmodule

// File: rtl/unal_bus_seq.sv
module unal_bus_seq
    import unal_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int REG_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [1:0]             size,
    input  logic                   we,
    input  logic [REG_BYTES*8-1:0] wdata,
    output logic [REG_BYTES*8-1:0] rd_data,
    output logic                   done,
    output logic                   bus_req,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic                   bus_we,
    output logic                   bus_lane_hi,
    output logic                   bus_lane_lo,
    output logic [15:0]            bus_wdata,
    input  logic [15:0]            bus_rdata,
    input  logic                   bus_ready
);
    localparam int REG_W = REG_BYTES * 8;
    localparam int PTR_W = $clog2(REG_BYTES + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [PTR_W-1:0]  nbytes;
        logic [PTR_W-1:0]  ptr;
        logic              we;
        logic [REG_W-1:0]  value;
        logic [REG_W-1:0]  acc;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] plan_addr;
    logic              plan_hi, plan_lo, plan_last;
    logic [PTR_W-1:0]  plan_step;
    logic [REG_W-1:0]  gathered;

    unal_beat_plan #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_plan (
        .base      (seq_q.base),
        .ptr       (seq_q.ptr),
        .nbytes    (seq_q.nbytes),
        .word_addr (plan_addr),
        .lane_hi   (plan_hi),
        .lane_lo   (plan_lo),
        .step      (plan_step),
        .last      (plan_last)
    );

    unal_wr_steer #(.REG_BYTES(REG_BYTES), .PTR_W(PTR_W)) u_steer (
        .value     (seq_q.value),
        .ptr       (seq_q.ptr),
        .lane_hi   (plan_hi),
        .lane_lo   (plan_lo),
        .bus_wdata (bus_wdata)
    );

    unal_rd_gather #(.REG_BYTES(REG_BYTES), .PTR_W(PTR_W)) u_gather (
        .acc_in    (seq_q.acc),
        .bus_rdata (bus_rdata),
        .ptr       (seq_q.ptr),
        .lane_hi   (plan_hi),
        .lane_lo   (plan_lo),
        .acc_out   (gathered)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st     = ST_BUSY;
                    seq_d.base   = addr;
                    seq_d.nbytes = PTR_W'(size_bytes(size));
                    seq_d.ptr    = '0;
                    seq_d.we     = we;
                    seq_d.value  = wdata;
                    seq_d.acc    = '0;
                end
            end
            ST_BUSY: begin
                if (bus_ready) begin
                    if (!seq_q.we) seq_d.acc = gathered;
                    seq_d.ptr = seq_q.ptr + plan_step;
                    if (plan_last) seq_d.st = ST_DONE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign bus_req     = (seq_q.st == ST_BUSY);
    assign bus_addr    = plan_addr;
    assign bus_we      = seq_q.we & bus_req;
    assign bus_lane_hi = plan_hi & bus_req;
    assign bus_lane_lo = plan_lo & bus_req;
    assign done        = (seq_q.st == ST_DONE);
    assign rd_data     = seq_q.acc;

    a_r7_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !bus_addr[0]);

    a_r1_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_lane_hi || bus_lane_lo));

    a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) &&
            $stable(bus_lane_hi) && $stable(bus_lane_lo) && $stable(bus_wdata)));

    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_req && bus_ready));

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

endmodule

// File: tb/unal_bus_seq_bench.sv
module unal_bus_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        done;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_we;
    logic        bus_lane_hi;
    logic        bus_lane_lo;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;

    always #10 clk = ~clk;

    unal_bus_seq u_unal_bus_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .size(size),
        .we(we), .wdata(wdata), .rd_data(rd_data), .done(done),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_lane_hi(bus_lane_hi), .bus_lane_lo(bus_lane_lo),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    typedef struct {
        logic [31:0] a;
        bit          wr;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        int          nb;
        logic [31:0] ba [3];
        bit          hi [3];
        bit          lo [3];
        string       tag;
    } exp_t;

    typedef struct {
        logic [31:0] a;
        bit          hi;
        bit          lo;
        logic [15:0] wd;
    } beat_t;

    exp_t  sbq [$];
    beat_t blog [$];
    logic [7:0] mem [logic [31:0]];

    int  nchk = 0, nfail = 0, n_done = 0, cyc = 0, n_stall = 0;
    bit  stall = 0, prev_done = 0, finished = 0;
    exp_t cur_e;

    function automatic logic [7:0] memrd(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] vbyte(logic [31:0] v, logic [31:0] off);
        return 8'(v >> (8 * off[1:0]));
    endfunction

    // Scoreboard monitor and bus responder, both half a clock from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (prev_done) check(0, "R10", "done held two cycles", 1, 0);
                if (sbq.size() == 0) check(0, "R11", "done with nothing pending", 1, 0);
                else begin
                    cur_e = sbq.pop_front();
                    check(blog.size() == cur_e.nb, cur_e.tag, "beat count", blog.size(), cur_e.nb);
                    for (int i = 0; i < cur_e.nb && i < blog.size(); i++) begin
                        check(blog[i].a == cur_e.ba[i], cur_e.tag, "beat address", blog[i].a, cur_e.ba[i]);
                        check({blog[i].hi, blog[i].lo} == {cur_e.hi[i], cur_e.lo[i]}, cur_e.tag,
                              "lane enables", {blog[i].hi, blog[i].lo}, {cur_e.hi[i], cur_e.lo[i]});
                        if (cur_e.wr) begin
                            logic [15:0] ew;
                            ew[15:8] = cur_e.hi[i] ? vbyte(cur_e.wd, cur_e.ba[i] - cur_e.a) : 8'h00;
                            ew[7:0]  = cur_e.lo[i] ? vbyte(cur_e.wd, cur_e.ba[i] + 1 - cur_e.a) : 8'h00;
                            check(blog[i].wd == ew, "R8", "write lanes", blog[i].wd, ew);
                        end
                    end
                    if (!cur_e.wr)
                        check(rd_data == cur_e.exp_rd, cur_e.tag, "read result", rd_data, cur_e.exp_rd);
                    n_done++;
                end
                blog.delete();
            end
            prev_done = done;
            bus_ready = !stall || (cyc % 3 != 0);
            cyc++;
            if (bus_req && !bus_ready) n_stall++;
            bus_rdata = {memrd(bus_addr), memrd(bus_addr + 1)};
            if (bus_req && bus_ready) begin
                blog.push_back('{a: bus_addr, hi: bus_lane_hi, lo: bus_lane_lo, wd: bus_wdata});
                if (bus_we) begin
                    if (bus_lane_hi) mem[bus_addr] = bus_wdata[15:8];
                    if (bus_lane_lo) mem[bus_addr + 1] = bus_wdata[7:0];
                end
            end
        end
    end

    // Driver: builds the expected item from the requirements, then issues it.
    task automatic acc(logic [31:0] a, logic [1:0] sz, bit wr, logic [31:0] wd, string tag, bit poke);
        exp_t e;
        int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        int tgt = n_done + 1;
        logic [31:0] w = {a[31:1], 1'b0};
        e.a = a; e.wr = wr; e.wd = wd; e.tag = tag; e.exp_rd = '0;
        for (int i = 0; i < 3; i++) begin e.ba[i] = '0; e.hi[i] = 0; e.lo[i] = 0; end
        if (!a[0]) begin
            e.nb = (n == 4) ? 2 : 1;
            e.ba[0] = w; e.hi[0] = 1; e.lo[0] = (n > 1);
            e.ba[1] = w + 2; e.hi[1] = 1; e.lo[1] = 1;
        end else if (n == 1) begin
            e.nb = 1; e.ba[0] = w; e.lo[0] = 1;
        end else begin
            e.nb = (n == 2) ? 2 : 3;
            e.ba[0] = w; e.lo[0] = 1;
            if (n == 2) begin e.ba[1] = a + 1; e.hi[1] = 1; end
            else begin
                e.ba[1] = a + 1; e.hi[1] = 1; e.lo[1] = 1;
                e.ba[2] = a + 3; e.hi[2] = 1;
            end
        end
        for (int k = 0; k < n; k++) e.exp_rd |= 32'(memrd(a + k)) << (8 * k);
        sbq.push_back(e);
        @(negedge clk);
        start = 1; addr = a; size = sz; we = wr; wdata = wd;
        @(negedge clk);
        start = 0;
        if (poke) begin
            @(negedge clk);
            start = 1; addr = 32'hDEAD0000; size = 2'd0; we = 1; wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            start = 0;
        end
        wait (n_done >= tgt);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done == 0, "R10", "done after reset", done, 0);
        check(bus_req == 0, "R10", "bus_req after reset", bus_req, 0);
        rst_n = 1;
        @(negedge clk);
        acc(32'h0000_0100, 2'd0, 0, 0, "R1", 0);
        acc(32'h0000_0101, 2'd0, 0, 0, "R2", 0);
        acc(32'h0000_0103, 2'd0, 0, 0, "R12", 0);
        acc(32'h0000_0200, 2'd1, 0, 0, "R3", 0);
        acc(32'h0000_0300, 2'd2, 0, 0, "R4", 0);
        acc(32'h0000_0401, 2'd1, 0, 0, "R5", 0);
        acc(32'h0000_0503, 2'd2, 0, 0, "R6", 0);
        acc(32'h1234_5677, 2'd2, 0, 0, "R7", 0);
        acc(32'hFFFF_FFFF, 2'd1, 0, 0, "R7", 0);
        acc(32'h0000_0601, 2'd2, 1, 32'hA1B2_C3D4, "R8", 0);
        acc(32'h0000_0601, 2'd2, 0, 0, "R8", 0);
        check(memrd(32'h0000_0600) == (8'h00 ^ 8'h06 ^ 8'h3C), "R8", "neighbour byte untouched",
              memrd(32'h0000_0600), 8'h00 ^ 8'h06 ^ 8'h3C);
        acc(32'h0000_0700, 2'd1, 1, 32'h0000_5E6F, "R8", 0);
        acc(32'h0000_0707, 2'd0, 1, 32'h0000_0099, "R8", 0);
        acc(32'h0000_0700, 2'd2, 0, 0, "R8", 0);
        stall = 1;
        acc(32'h0000_0803, 2'd2, 0, 0, "R9", 0);
        acc(32'h0000_0900, 2'd2, 1, 32'h1122_3344, "R9", 0);
        check(n_stall > 0, "R9", "stall cycles seen", n_stall, 1);
        acc(32'h0000_0A01, 2'd2, 0, 0, "R11", 1);
        stall = 0;
        acc(32'h0000_0B00, 2'd0, 0, 0, "R11", 0);
        check(!mem.exists(32'hDEAD0000), "R11", "ignored start wrote memory", 1, 0);
        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R11", "pending items at end", sbq.size(), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

endmodule